// File: doc/BRIEF.md
# MDIO Clause 22 Management Master

This block runs single register read and write transactions towards external PHY devices over a two-wire serial management link. The link is a management clock output plus one bidirectional data line. The data line is split into a driven value, an output enable and a sampled input, so that the pad buffer sits outside the block. A host issues one request at a time. Each request gives a read/write flag, a device-select bit, a 5-bit register number and 16 bits of write data. The block then shifts out a 64-bit frame and, for reads, returns the register contents together with a one-cycle completion pulse.

The host does not supply the 5-bit PHY address with each request. Two programmable address registers hold it instead, and the device-select bit chooses between them. The address is latched when the request is accepted. A later reprogramming of the registers therefore never changes a frame that is already in flight. The management clock is derived from the system clock by dividing it, and it toggles only while a transaction is running.

Top module: `mdio_mgmt_master`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `mdc`, `mdio_oe` and `no_ack_err` are 0 and `rdata` is 0; the PHY address registers take the values of `PHYAD0_RST` and `PHYAD1_RST`.
- R2: While idle, `mdc` is held low. During a transaction `mdc` runs with a period of 2*`HALF_DIV` system clock cycles, and every transaction contains exactly 64 rising edges of `mdc`.
- R3: Frame bits 0 to 31 (in transmit order) are all 1, and bits 32 and 33 are 0 then 1.
- R4: Bits 34 and 35 are the opcode, sent MSB first: 1,0 for a read (`cmd_read`=1) and 0,1 for a write.
- R5: Bits 36 to 40 carry the PHY address MSB first. It is taken from address register 0 when `cmd_dev`=0 and from address register 1 when `cmd_dev`=1. A pulse on `cfg_we` loads `cfg_phyad` into the register chosen by `cfg_sel`.
- R6: Bits 41 to 45 carry `cmd_reg` MSB first.
- R7: On a write, `mdio_oe` is high for all 64 bits, bits 46 and 47 are 1 then 0, and bits 48 to 63 are `cmd_wdata` MSB first.
- R8: On a read, `mdio_oe` is low from bit 46 to the end of the frame. The line is sampled at the `mdc` rising edges of bits 48 to 63 as read data, MSB first, and the result appears on `rdata` together with `done`.
- R9: `mdio_o` and `mdio_oe` change only when `mdc` falls (or at request acceptance) and are constant while `mdc` is high.
- R10: A request (`cmd_valid` while `busy` is low) raises `busy` in the next cycle. `busy` stays high until the falling `mdc` edge after the 64th bit. `done` pulses for exactly one cycle as `busy` drops. A `cmd_valid` while `busy` is high is ignored.
- R11: At the end of a read, `no_ack_err` is 1 if the line was sampled as 1 at bit 47 and 0 otherwise. A completed write clears it.
- R12: `mdio_oe` is low whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, taken when not busy |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_dev | input | 1 | Selects PHY address register 0 or 1 |
| cmd_reg | input | 5 | Register number inside the PHY |
| cmd_wdata | input | 16 | Write data |
| cfg_we | input | 1 | Load strobe for a PHY address register |
| cfg_sel | input | 1 | Which address register `cfg_we` loads |
| cfg_phyad | input | 5 | New PHY address value |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data returned by the last read |
| no_ack_err | output | 1 | Last read saw no PHY drive at bit 47 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the master |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line value seen at the pad |

## Verification
The hardest situation to reach from the ports is a request that arrives in the middle of a frame. It must leave the running frame and the following idle period untouched. The bench raises `cmd_valid` with inverted fields part way through selected frames, then checks that the captured frame is the original one and that `busy` stays low after `done`. The silent-PHY case is also created on purpose: for some reads the bench model never drives bit 47 low, and it expects `no_ack_err` on those reads only. The address registers are reprogrammed in the middle of the sweep, using the extreme values 0 and 31.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int TA_FIRST   = 46;   // first turnaround bit index
  localparam int TA_LAST    = 47;   // bit on which the PHY must pull low
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef struct packed {
    logic              rd;
    logic              dev;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(
      input mdio_req_t req, input logic [ADDR_W-1:0] phyad);
    logic [1:0]        op;
    logic [1:0]        ta;
    logic [DATA_W-1:0] dat;
    op  = req.rd ? OP_RD : OP_WR;
    ta  = req.rd ? 2'b00 : TA_WR;
    dat = req.rd ? '0 : req.wdata;
    return {{32{1'b1}}, ST_CODE, op, phyad, req.regad, ta, dat};
  endfunction
endpackage

// File: rtl/mdio_addr_regs.sv
`timescale 1ns/1ps
module mdio_addr_regs #(
  parameter int AW = 5,
  parameter logic [AW-1:0] RST0 = '0,
  parameter logic [AW-1:0] RST1 = AW'(1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel,
  input  logic [AW-1:0] wval,
  input  logic          dev,
  output logic [AW-1:0] phyad
);
  localparam int NREG = 2;
  localparam logic [NREG*AW-1:0] RST_ALL = {RST1, RST0};

  logic [AW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= RST_ALL[g*AW +: AW];
      else if (we && (sel == 1'(g)))
        regs_q[g] <= wval;
    end
  end

  assign phyad = regs_q[dev];
endmodule

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap     = en && (cnt_q == LAST);
  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic [ADDR_W-1:0] phyad,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              no_ack,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic [IDX_W-1:0]      idx_nx;
  logic                  rd_q;
  logic                  ta_q;
  logic [DATA_W-1:0]     rsh_q;
  logic                  drive_nx;

  assign idx_nx   = idx_q + IDX_W'(1);
  assign drive_nx = !rd_q || (int'(idx_nx) < TA_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      ta_q    <= 1'b1;
      rsh_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
      no_ack  <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q    <= build_frame(req, phyad);
        idx_q   <= '0;
        rd_q    <= req.rd;
        ta_q    <= 1'b1;
        busy    <= 1'b1;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
      end else if (busy) begin
        if (rise_evt) begin
          if (int'(idx_q) == TA_LAST)
            ta_q <= mdio_i;
          if (int'(idx_q) >= DATA_FIRST)
            rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
        end
        if (fall_evt) begin
          if (idx_q == LAST_BIT) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            if (rd_q) begin
              rdata  <= rsh_q;
              no_ack <= ta_q;
            end else begin
              no_ack <= 1'b0;
            end
          end else begin
            idx_q   <= idx_nx;
            sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
            mdio_o  <= sh_q[FRAME_BITS-2] && drive_nx;
            mdio_oe <= drive_nx;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter logic [ADDR_W-1:0] PHYAD0_RST = '0,
  parameter logic [ADDR_W-1:0] PHYAD1_RST = ADDR_W'(1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic              cmd_dev,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_phyad,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              no_ack_err,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_req_t         req;
  logic [ADDR_W-1:0] phyad;
  logic              accept;
  logic              rise_evt;
  logic              fall_evt;

  assign req    = '{rd: cmd_read, dev: cmd_dev, regad: cmd_reg, wdata: cmd_wdata};
  assign accept = cmd_valid && !busy;

  mdio_addr_regs #(
    .AW(ADDR_W), .RST0(PHYAD0_RST), .RST1(PHYAD1_RST)
  ) addr_i (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wval(cfg_phyad),
    .dev(cmd_dev), .phyad(phyad)
  );

  mdio_clk_div #(.HALF(HALF_DIV)) div_i (
    .clk(clk), .rst(rst), .en(busy), .mdc(mdc),
    .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine eng_i (
    .clk(clk), .rst(rst), .start(accept), .req(req), .phyad(phyad),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .done(done), .rdata(rdata), .no_ack(no_ack_err),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_master_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mdc && !mdio_oe));

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r12_idle_released: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  a_r2_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  a_r9_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0, cmd_dev = 1'b0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [4:0]  cfg_phyad = '0;
  logic        busy, done, no_ack_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;
  logic        mdio_i = 1'b1;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  logic [4:0] phy0 = 5'd0;
  logic [4:0] phy1 = 5'd1;

  always #(CLK_P/2) clk = ~clk;

  mdio_mgmt_master #(.HALF_DIV(HALF)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_dev(cmd_dev), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_phyad(cfg_phyad),
    .busy(busy), .done(done), .rdata(rdata), .no_ack_err(no_ack_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_phy(input logic sel, input logic [4:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_phyad = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) phy1 = val; else phy0 = val;
  endtask

  task automatic run_txn(input logic rd, input logic dev, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rsp,
                         input logic ack, input logic inject);
    logic [63:0] co, coe, eo, eoe;
    logic [4:0]  pa;
    time         t0, t1;
    pa  = dev ? phy1 : phy0;
    eo  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
           rd ? 18'h0 : {2'b10, wd}};
    eoe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    co = '0; coe = '0; t0 = 0; t1 = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_dev = dev; cmd_reg = ra;
    cmd_wdata = wd; mdio_i = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R10 busy after request", 64'(busy), 64'd1);
    for (int k = 0; k < 64; k++) begin
      if (rd && ack && k == 47)      mdio_i = 1'b0;
      else if (rd && ack && k >= 48) mdio_i = rsp[63-k];
      else                           mdio_i = 1'b1;
      @(posedge mdc);
      #1;
      co[63-k]  = mdio_o;
      coe[63-k] = mdio_oe;
      if (k == 0) t0 = $time;
      if (k == 1) t1 = $time;
      if (inject && k == 20) begin
        cmd_valid = 1'b1; cmd_read = ~rd; cmd_dev = ~dev; cmd_reg = ~ra;
        cmd_wdata = ~wd;
      end
      if (inject && k == 21) cmd_valid = 1'b0;
      @(negedge mdc);
    end
    #1;
    mdio_i = 1'b1;
    chk(co[63:30] == eo[63:30], "R3 preamble/start", co[63:30], eo[63:30]);
    chk(co[29:28] == eo[29:28], "R4 opcode", co[29:28], eo[29:28]);
    chk(co[27:23] == eo[27:23], "R5 phy address", co[27:23], eo[27:23]);
    chk(co[22:18] == eo[22:18], "R6 register address", co[22:18], eo[22:18]);
    if (rd) begin
      chk(coe == eoe, "R8 read release", coe, eoe);
      chk(rdata == rsp || !ack, "R8 read data", rdata, rsp);
    end else begin
      chk(coe == eoe && co[17:0] == eo[17:0], "R7 write tail",
          {coe[17:0], co[17:0]}, {eoe[17:0], eo[17:0]});
    end
    chk(t1 - t0 == time'(2*HALF*CLK_P), "R2 mdc period", t1 - t0,
        64'(2*HALF*CLK_P));
    chk(done === 1'b1 && busy === 1'b0, "R10 done at end", {done, busy}, 2'b10);
    chk(no_ack_err === (rd && !ack), "R11 no-ack flag", no_ack_err, rd && !ack);
    @(posedge clk);
    #1;
    chk(done === 1'b0 && busy === 1'b0, "R10 single done, ignored request",
        {done, busy}, 2'b00);
    chk(mdio_oe === 1'b0 && mdc === 1'b0, "R12 idle released, R2 mdc low",
        {mdio_oe, mdc}, 2'b00);
  endtask

  initial begin
    #(CLK_P*200000);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog R10 act=hung exp=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk({busy, done, mdc, mdio_oe, no_ack_err} == 5'b0 && rdata == 16'h0,
        "R1 reset state", {busy, done, mdc, mdio_oe, no_ack_err, rdata}, 64'h0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 after reset",
        {busy, done, mdc, mdio_oe}, 64'h0);
    // reset-default addresses (R5)
    run_txn(1'b0, 1'b1, 5'd3, 16'h1234, 16'h0, 1'b1, 1'b0);
    run_txn(1'b1, 1'b0, 5'd9, 16'h0, 16'hBEEF, 1'b1, 1'b0);
    set_phy(1'b0, 5'h13);
    set_phy(1'b1, 5'h0A);
    for (int rd = 0; rd < 2; rd++) begin
      for (int dv = 0; dv < 2; dv++) begin
        if (rd == 1 && dv == 0) begin
          set_phy(1'b0, 5'h1F);
          set_phy(1'b1, 5'h00);
        end
        for (int ra = 0; ra < 32; ra++) begin
          logic [15:0] wd, rs;
          logic        ack;
          wd  = 16'hA5C3 ^ 16'(ra << 7) ^ 16'(dv);
          rs  = 16'h3C5A + 16'(ra * 977) + 16'(dv * 16'h8001);
          ack = !(rd == 1 && ra[2:0] == 3'd7);
          run_txn(1'(rd), 1'(dv), 5'(ra), wd, rs, ack, ra == 5 || ra == 30);
        end
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule